// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a 4 kB direct-mapped data cache for a 32-bit load/store port. Each of its 256 lines holds four 32-bit words and has one tag and one valid bit. A cacheable read that misses fetches the whole four-word line from the memory port and installs it. Then the block answers the read from the freshly written line. Stores are write-through. A store that hits updates the cached bytes and also goes to memory. A store that misses goes to memory only and allocates nothing.

Any address with bit 31 set is uncached. Such a read or write goes to the memory port as a single word transfer and never touches the tag or data storage. This keeps buffers shared with DMA engines coherent. The CPU holds a request until the block pulses `cpu_ready`. The memory side uses the same hold-until-acknowledge rule. A cacheable read hit completes in the cycle it is presented. Every other access stalls the CPU until its memory traffic is done.

Top module: `dcache_top`

## Requirements
- R1: The address splits as tag = addr[31:12], line index = addr[11:4], word select = addr[3:2], byte offset = addr[1:0]. After a read miss at 0x12345678, reads of 0x12345670, 0x12345674 and 0x1234567C all hit in line 0x67.
- R2: Reset clears every valid bit, so the first cacheable read of any line misses. After reset, `cpu_ready` and `mem_req` are low.
- R3: A cacheable read hit asserts `cpu_ready` in the same cycle as the request, returns the cached word and issues no memory request.
- R4: On a cacheable read miss, the block issues exactly four memory reads (`mem_we` = 0) at line base +0, +4, +8 and +12, in that order. `cpu_ready` rises one cycle after the fourth acknowledge, carrying the requested word.
- R5: A read miss whose tag differs from the tag resident at that index replaces the line, so a later read of the old tag misses again.
- R6: A cacheable store hit merges the bytes selected by `cpu_be` (bit n covers data bits 8n+7:8n) into the cached word. It also issues one memory write with the same address, byte enables and data. `cpu_ready` is asserted in the cycle of that write's acknowledge.
- R7: A cacheable store miss issues one memory write and leaves the cache unchanged, so a later read of that address misses and refills.
- R8: When addr[31] = 1, a read or write makes one memory transfer at the CPU address. A read returns `mem_rdata` directly, and repeating the access never hits.
- R9: Once `mem_req` is raised, it stays high with the same address and direction until `mem_ack`.
- R10: `cpu_ready` is high only while `cpu_req` is high, for one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Byte enables for stores |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access complete |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer direction, 1 = write |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory transfer complete |

## Verification
The bench aims at words in the same line after a refill. A wrong split of tag and index bits would make these refetch, or return a neighbour's word. It checks the refill burst order and the cycle when the CPU is released. A design that answered from a half-written line, or stepped the word counter wrongly, shows the wrong address sequence or releases the CPU early. It checks conflicting tags at one index and store hits followed by loads. A missed replacement or a dropped byte merge returns stale data with no memory traffic. Store misses and addresses with bit 31 set catch a design that allocates on writes or caches the uncached region: the expected refill or memory transfer never appears.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int INDEX_W = 8;
    localparam int WSEL_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_STORE,
        ST_UNCACHED
    } dc_state_e;

endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store
    import dcache_pkg::*;
#(
    parameter int INDEX_W = dcache_pkg::INDEX_W,
    parameter int TAG_W   = 20,
    localparam int DEPTH  = 2 ** INDEX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]   wr_tag
);

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/dcache_line_store.sv
module dcache_line_store
    import dcache_pkg::*;
#(
    parameter int DATA_W  = dcache_pkg::DATA_W,
    parameter int INDEX_W = dcache_pkg::INDEX_W,
    parameter int WSEL_W  = dcache_pkg::WSEL_W,
    localparam int WORDS  = 2 ** WSEL_W,
    localparam int BYTES  = DATA_W / 8,
    localparam int DEPTH  = 2 ** INDEX_W
) (
    input  logic                         clk,
    input  logic [INDEX_W-1:0]           rd_idx,
    output logic [WORDS-1:0][DATA_W-1:0] rd_line,
    input  logic                         wr_en,
    input  logic [INDEX_W-1:0]           wr_idx,
    input  logic [WSEL_W-1:0]            wr_word,
    input  logic [BYTES-1:0]             wr_be,
    input  logic [DATA_W-1:0]            wr_data
);

    logic [WORDS-1:0][DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wr_be[b]) begin
                    mem_q[wr_idx][wr_word][8*b +: 8] <= wr_data[8*b +: 8];
                end
            end
        end
    end

    assign rd_line = mem_q[rd_idx];

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int ADDR_W  = dcache_pkg::ADDR_W,
    parameter int DATA_W  = dcache_pkg::DATA_W,
    parameter int WSEL_W  = dcache_pkg::WSEL_W,
    localparam int BYTES  = DATA_W / 8,
    localparam int OFS_W  = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTES-1:0]  cpu_be,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              hit,
    input  logic              cacheable,
    input  logic [DATA_W-1:0] hit_word,
    output logic              line_we,
    output logic [WSEL_W-1:0] line_word,
    output logic [BYTES-1:0]  line_be,
    output logic [DATA_W-1:0] line_data,
    output logic              tag_we,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    localparam logic [WSEL_W-1:0] LAST_WORD = '1;

    dc_state_e         state_q, state_d;
    logic [WSEL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL && mem_ack) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (state_q == ST_IDLE) begin
                cnt_q <= '0;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_rdata = hit_word;
        line_we   = 1'b0;
        line_word = cpu_addr[OFS_W +: WSEL_W];
        line_be   = cpu_be;
        line_data = cpu_wdata;
        tag_we    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cpu_addr;
        mem_be    = cpu_be;
        mem_wdata = cpu_wdata;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        line_we = hit;
                        state_d = ST_STORE;
                    end else if (!cacheable) begin
                        state_d = ST_UNCACHED;
                    end else if (hit) begin
                        cpu_ready = 1'b1;
                    end else begin
                        state_d = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_addr  = {cpu_addr[ADDR_W-1:WSEL_W+OFS_W], cnt_q, {OFS_W{1'b0}}};
                mem_be    = '1;
                line_word = cnt_q;
                line_be   = '1;
                line_data = mem_rdata;
                if (mem_ack) begin
                    line_we = 1'b1;
                    if (cnt_q == LAST_WORD) begin
                        tag_we  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_STORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_UNCACHED: begin
                mem_req   = 1'b1;
                cpu_rdata = mem_rdata;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_FILL_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL && mem_ack && cnt_q != LAST_WORD) |=>
        (mem_addr[OFS_W +: WSEL_W] == WSEL_W'($past(mem_addr[OFS_W +: WSEL_W]) + 1'b1))); // R4

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9

    AST_READY_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_req); // R10

    AST_NO_WRITE_ALLOCATE: assert property (@(posedge clk) disable iff (rst)
        (line_we && state_q == ST_IDLE) |-> hit); // R7

endmodule

// File: rtl/dcache_top.sv
module dcache_top
    import dcache_pkg::*;
#(
    parameter int ADDR_W  = dcache_pkg::ADDR_W,
    parameter int DATA_W  = dcache_pkg::DATA_W,
    parameter int INDEX_W = dcache_pkg::INDEX_W,
    parameter int WSEL_W  = dcache_pkg::WSEL_W,
    localparam int BYTES  = DATA_W / 8,
    localparam int OFS_W  = $clog2(BYTES),
    localparam int TAG_W  = ADDR_W - INDEX_W - WSEL_W - OFS_W,
    localparam int WORDS  = 2 ** WSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTES-1:0]  cpu_be,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    logic [TAG_W-1:0]             addr_tag;
    logic [INDEX_W-1:0]           addr_idx;
    logic [WSEL_W-1:0]            addr_word;
    logic                         cacheable;
    logic                         hit;
    logic                         rd_valid;
    logic [TAG_W-1:0]             rd_tag;
    logic [WORDS-1:0][DATA_W-1:0] rd_line;
    logic [DATA_W-1:0]            hit_word;
    logic                         line_we;
    logic [WSEL_W-1:0]            line_word;
    logic [BYTES-1:0]             line_be;
    logic [DATA_W-1:0]            line_data;
    logic                         tag_we;

    assign addr_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign addr_idx  = cpu_addr[OFS_W+WSEL_W +: INDEX_W];
    assign addr_word = cpu_addr[OFS_W +: WSEL_W];
    assign cacheable = !cpu_addr[ADDR_W-1];
    assign hit       = cacheable && rd_valid && (rd_tag == addr_tag);
    assign hit_word  = rd_line[addr_word];

    dcache_tag_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (addr_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .wr_en    (tag_we),
        .wr_idx   (addr_idx),
        .wr_tag   (addr_tag)
    );

    dcache_line_store #(
        .DATA_W  (DATA_W),
        .INDEX_W (INDEX_W),
        .WSEL_W  (WSEL_W)
    ) u_lines (
        .clk     (clk),
        .rd_idx  (addr_idx),
        .rd_line (rd_line),
        .wr_en   (line_we),
        .wr_idx  (addr_idx),
        .wr_word (line_word),
        .wr_be   (line_be),
        .wr_data (line_data)
    );

    dcache_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WSEL_W (WSEL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_be    (cpu_be),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .hit       (hit),
        .cacheable (cacheable),
        .hit_word  (hit_word),
        .line_we   (line_we),
        .line_word (line_word),
        .line_be   (line_be),
        .line_data (line_data),
        .tag_we    (tag_we),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    AST_BYPASS_NO_TAG: assert property (@(posedge clk) disable iff (rst)
        tag_we |-> !cpu_addr[ADDR_W-1]); // R8

endmodule

// File: tb/tb_dcache_top.sv
module tb_dcache_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;
    int stable_err = 0;
    int txn_total = 0;

    logic [31:0] mem_model [logic [29:0]];
    bit          ref_valid [256];
    logic [19:0] ref_tag   [256];

    logic [31:0] q_addr [$];
    bit          q_we   [$];
    logic [3:0]  q_be   [$];
    logic [31:0] q_data [$];
    int          q_cyc  [$];

    dcache_top dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] model_rd(input logic [31:0] a);
        if (mem_model.exists(a[31:2])) return mem_model[a[31:2]];
        return {a[31:2], 2'b00} ^ 32'h3C3C_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory responder: latency 0..2 cycles, records each completed transfer
    initial begin
        int wait_cnt;
        logic [31:0] held_addr;
        bit held_we;
        wait_cnt = 0;
        held_addr = '0;
        held_we = 1'b0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                wait_cnt = 0;
            end else if (mem_req && !rst) begin
                if (wait_cnt == 0) begin
                    held_addr = mem_addr;
                    held_we = mem_we;
                end else if (mem_addr != held_addr || mem_we != held_we) begin
                    stable_err++;
                end
                if (wait_cnt >= (txn_total % 3)) begin
                    if (mem_we) begin
                        logic [31:0] w;
                        w = model_rd(mem_addr);
                        for (int b = 0; b < 4; b++)
                            if (mem_be[b]) w[8*b +: 8] = mem_wdata[8*b +: 8];
                        mem_model[mem_addr[31:2]] = w;
                    end else begin
                        mem_rdata = model_rd(mem_addr);
                    end
                    q_addr.push_back(mem_addr);
                    q_we.push_back(mem_we);
                    q_be.push_back(mem_be);
                    q_data.push_back(mem_wdata);
                    q_cyc.push_back(cyc);
                    txn_total++;
                    mem_ack = 1'b1;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] a, input logic [3:0] be, input logic [31:0] wd);
        bit cach, hit;
        logic [7:0] idx;
        logic [31:0] exp_rd, got;
        int start_cyc, rdy_cyc, waited;
        cach = !a[31];
        idx = a[11:4];
        hit = cach && ref_valid[idx] && (ref_tag[idx] == a[31:12]);
        exp_rd = model_rd(a);
        q_addr.delete(); q_we.delete(); q_be.delete(); q_data.delete(); q_cyc.delete();
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
        start_cyc = cyc;
        waited = 0;
        #1;
        while (!cpu_ready && waited < 200) begin
            @(negedge clk);
            #1;
            waited++;
        end
        rdy_cyc = cyc;
        got = cpu_rdata;
        chk(cpu_ready, "R10 ready reached", {31'b0, cpu_ready}, 32'h1);
        if (we) begin
            chk(q_addr.size() == 1, "R6/R7/R8 one memory write", q_addr.size(), 1);
            if (q_addr.size() == 1) begin
                chk(q_we[0] && q_addr[0] == a, "R6/R7/R8 write address", q_addr[0], a);
                chk(q_be[0] == be && q_data[0] == wd, "R6 write be/data", {q_be[0], q_data[0][27:0]}, {be, wd[27:0]});
                chk(rdy_cyc == q_cyc[0], "R6 ready with write ack", rdy_cyc, q_cyc[0]);
            end
        end else if (!cach) begin
            chk(q_addr.size() == 1, "R8 uncached single read", q_addr.size(), 1);
            if (q_addr.size() == 1)
                chk(!q_we[0] && q_addr[0] == a, "R8 uncached read address", q_addr[0], a);
            chk(got == exp_rd, "R8 uncached read data", got, exp_rd);
        end else if (hit) begin
            chk(q_addr.size() == 0, "R3 hit has no memory traffic", q_addr.size(), 0);
            chk(rdy_cyc == start_cyc, "R3 hit same cycle", rdy_cyc - start_cyc, 0);
            chk(got == exp_rd, "R1/R3 hit data", got, exp_rd);
        end else begin
            chk(q_addr.size() == 4, "R4 refill count", q_addr.size(), 4);
            if (q_addr.size() == 4) begin
                for (int i = 0; i < 4; i++) begin
                    logic [31:0] ea;
                    ea = {a[31:4], 4'(i * 4)};
                    chk(!q_we[i] && q_addr[i] == ea, "R4 refill order", q_addr[i], ea);
                end
                chk(rdy_cyc == q_cyc[3] + 1, "R4 ready after line", rdy_cyc, q_cyc[3] + 1);
            end
            chk(got == exp_rd, "R4 miss data", got, exp_rd);
            ref_valid[idx] = 1'b1;
            ref_tag[idx] = a[31:12];
        end
        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        chk(!cpu_ready, "R10 ready only with request", {31'b0, cpu_ready}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ref_valid[i] = 1'b0;
            ref_tag[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R2: quiet after reset
        chk(!cpu_ready && !mem_req, "R2 reset outputs", {30'b0, cpu_ready, mem_req}, 32'h0);

        // R2/R4/R1: first read misses, then words of line 0x67 hit
        access(1'b0, 32'h1234_5678, 4'hF, '0);
        access(1'b0, 32'h1234_5670, 4'hF, '0);
        access(1'b0, 32'h1234_5674, 4'hF, '0);
        access(1'b0, 32'h1234_567C, 4'hF, '0);
        chk(ref_valid[8'h67] && ref_tag[8'h67] == 20'h12345, "R1 line index and tag", {12'b0, ref_tag[8'h67]}, 32'h12345);

        // R5: conflicting tag replaces line, old tag misses again
        access(1'b0, 32'h0543_2674, 4'hF, '0);
        access(1'b0, 32'h0543_2670, 4'hF, '0);
        access(1'b0, 32'h1234_5670, 4'hF, '0);

        // R6: store hit merges bytes, read hit sees merged data
        access(1'b1, 32'h1234_5674, 4'b0101, 32'hAABB_CCDD);
        access(1'b0, 32'h1234_5674, 4'hF, '0);
        access(1'b1, 32'h1234_567C, 4'b1000, 32'h7700_0000);
        access(1'b0, 32'h1234_567C, 4'hF, '0);

        // R7: store miss, later read refills with stored data
        access(1'b1, 32'h0000_1004, 4'hF, 32'hDEAD_BEEF);
        chk(!ref_valid[8'h00], "R7 no allocate on store miss", {31'b0, ref_valid[8'h00]}, 32'h0);
        access(1'b0, 32'h0000_1004, 4'hF, '0);
        access(1'b0, 32'h0000_1000, 4'hF, '0);

        // R8: uncached region never fills
        access(1'b0, 32'h8000_0010, 4'hF, '0);
        access(1'b0, 32'h8000_0010, 4'hF, '0);
        access(1'b1, 32'h8000_0020, 4'hF, 32'h1357_9BDF);
        access(1'b0, 32'h8000_0020, 4'hF, '0);
        access(1'b1, 32'h9234_5670, 4'hF, 32'h0BAD_F00D);
        access(1'b0, 32'h1234_5670, 4'hF, '0);

        // Index sweep: miss then hit on several lines
        for (int i = 0; i < 8; i++) access(1'b0, 32'h0020_0000 + 32'(i * 16 + 8), 4'hF, '0);
        for (int i = 0; i < 8; i++) access(1'b0, 32'h0020_0000 + 32'(i * 16 + 4), 4'hF, '0);

        // R9: request held stable until acknowledge
        chk(stable_err == 0, "R9 memory request stable", stable_err, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule